// File: doc/BRIEF.md
# BCD Calendar Counter with Coherent-Access Freeze

This block keeps wall-clock time and date (seconds through century) as packed BCD bytes and advances once for every pulse on a one-per-second tick input. A host reaches the eight time fields and one control byte over a simple byte-wide register port. Writes take effect at the clock edge. Read data is combinational from the host-visible copy.

Software clears a transfer-enable bit in the control byte before it reads or rewrites a group of fields, so that it sees or builds a consistent snapshot. While the bit is clear, the host-visible copy holds still and a hidden running copy keeps counting. Setting the bit again merges the two copies. Fields that the host wrote during the freeze replace the running values. Fields it left alone keep the running count, so no seconds are lost.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00, century 0x20, and the control byte reads 0x80.
- R2: Fields sit at addresses 0x0 seconds, 0x1 minutes, 0x2 hours, 0x3 weekday, 0x4 date, 0x5 month, 0x6 year, 0x7 century. Addresses 0x8 to 0xE read 0x00 and writes to them are ignored.
- R3: Each tick adds one second. Seconds 59 wrap to 00 and carry into minutes. Minutes 59 wrap to 00 and carry into hours. Hours 23 wrap to 00 and start a new day.
- R4: The weekday field counts 1 to 7 and goes from 7 back to 1 on each new day.
- R5: On a new day the date goes back to 01 after day 30 in April, June, September and November, and after day 31 in the other months except February.
- R6: February ends after day 29 when the year value (read as decimal from its BCD digits) is a multiple of 4, and after day 28 otherwise.
- R7: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and carries into the century.
- R8: A write to the month address stores only bits 4:0. Bits 7:5 of the month byte keep reading 0 whatever the write data.
- R9: Address 0xF is the control byte. Bit 7 is transfer enable and reads back as written. All other control bits read 0.
- R10: While transfer enable is 0, the fields at 0x0 to 0x7 read unchanged across ticks. A host write during the freeze is visible on the next read.
- R11: In the cycle after transfer enable goes from 0 to 1, every field written during the freeze holds the written value. Every other field holds the running count, including ticks that arrived during the freeze.
- R12: While transfer enable is 1, a field write is readable in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse that advances the time by one second |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
Ticks and writes sampled at clock edge k show on bus_rdata after edge k. Because the read path has no register, the bench drives inputs just after a rising edge and compares at the following falling edge. A behavioural time model steps on the same edge and is compared at every falling edge for the address on the port. Directed reads place the expected value one edge after the stimulus: a rollover, a write, a freeze and a release.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NUM_FIELDS = 8;
    localparam int FIELD_W    = 8;
    localparam int ADDR_W     = 4;
    localparam int IDX_W      = $clog2(NUM_FIELDS);
    localparam int TE_BIT     = 7;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'hF;
    localparam int F_SEC = 0, F_MIN = 1, F_HR = 2, F_DOW = 3;
    localparam int F_DATE = 4, F_MON = 5, F_YR = 6, F_CEN = 7;

    typedef logic [FIELD_W-1:0] fld_t;
    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] cal_t;

    typedef struct packed {
        cal_t                  run;
        cal_t                  vis;
        logic [NUM_FIELDS-1:0] dirty;
        logic                  te;
    } state_t;

    function automatic fld_t field_mask(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_W'(F_SEC), IDX_W'(F_MIN):  return 8'h7F;
            IDX_W'(F_HR), IDX_W'(F_DATE):  return 8'h3F;
            IDX_W'(F_DOW):                 return 8'h07;
            IDX_W'(F_MON):                 return 8'h1F;
            default:                       return 8'hFF;
        endcase
    endfunction

    // {carry, next}: wraps to first once v reaches last, else BCD +1
    function automatic logic [FIELD_W:0] bcd_step(input fld_t v, input fld_t last,
                                                  input fld_t first);
        if (v >= last)
            return {1'b1, first};
        else if (v[3:0] >= 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'h0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic cal_t reset_cal();
        cal_t c;
        c        = '0;
        c[F_DOW]  = 8'h01;
        c[F_DATE] = 8'h01;
        c[F_MON]  = 8'h01;
        c[F_CEN]  = 8'h20;
        return c;
    endfunction

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_cal_pkg::*;
(
    input  fld_t month,
    input  fld_t year,
    output fld_t last_day
);
    logic [7:0] year_bin;
    logic       leap;

    always_comb begin
        year_bin = {4'b0, year[7:4]} * 8'd10 + {4'b0, year[3:0]};
        leap     = (year_bin[1:0] == 2'b00);
        case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_cal_adv.sv
module rtc_cal_adv
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    fld_t             last_day;
    logic [FIELD_W:0] st;
    logic             carry;

    rtc_month_len u_mlen (
        .month    (cur[F_MON]),
        .year     (cur[F_YR]),
        .last_day (last_day)
    );

    always_comb begin
        nxt   = cur;
        st    = bcd_step(cur[F_SEC], 8'h59, 8'h00);
        nxt[F_SEC] = st[FIELD_W-1:0];
        carry = st[FIELD_W];
        if (carry) begin
            st = bcd_step(cur[F_MIN], 8'h59, 8'h00);
            nxt[F_MIN] = st[FIELD_W-1:0];
            carry = st[FIELD_W];
        end
        if (carry) begin
            st = bcd_step(cur[F_HR], 8'h23, 8'h00);
            nxt[F_HR] = st[FIELD_W-1:0];
            carry = st[FIELD_W];
        end
        if (carry) begin
            st = bcd_step(cur[F_DOW], 8'h07, 8'h01);
            nxt[F_DOW] = st[FIELD_W-1:0];
            st = bcd_step(cur[F_DATE], last_day, 8'h01);
            nxt[F_DATE] = st[FIELD_W-1:0];
            carry = st[FIELD_W];
        end
        if (carry) begin
            st = bcd_step(cur[F_MON], 8'h12, 8'h01);
            nxt[F_MON] = st[FIELD_W-1:0];
            carry = st[FIELD_W];
        end
        if (carry) begin
            st = bcd_step(cur[F_YR], 8'h99, 8'h00);
            nxt[F_YR] = st[FIELD_W-1:0];
            carry = st[FIELD_W];
        end
        if (carry) begin
            st = bcd_step(cur[F_CEN], 8'h99, 8'h00);
            nxt[F_CEN] = st[FIELD_W-1:0];
        end
    end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [FIELD_W-1:0] bus_wdata,
    output logic [FIELD_W-1:0] bus_rdata
);
    state_t          s_d, s_q;
    cal_t            adv_time;
    cal_t            run_next;
    logic            field_sel;
    logic            ctrl_sel;
    logic [IDX_W-1:0] idx;
    fld_t            wval;

    rtc_cal_adv u_adv (
        .cur (s_q.run),
        .nxt (adv_time)
    );

    always_comb begin
        field_sel = (bus_addr < ADDR_W'(NUM_FIELDS));
        ctrl_sel  = (bus_addr == CTRL_ADDR);
        idx       = bus_addr[IDX_W-1:0];
        wval      = bus_wdata & field_mask(idx);
        run_next  = tick_1hz ? adv_time : s_q.run;

        s_d     = s_q;
        s_d.run = run_next;
        if (s_q.te) begin
            if (bus_we && field_sel)
                s_d.run[idx] = wval;
            if (bus_we && ctrl_sel && !bus_wdata[TE_BIT])
                s_d.te = 1'b0;
            s_d.vis = s_d.run;
        end else begin
            if (bus_we && field_sel) begin
                s_d.vis[idx]   = wval;
                s_d.dirty[idx] = 1'b1;
            end
            if (bus_we && ctrl_sel && bus_wdata[TE_BIT]) begin
                for (int i = 0; i < NUM_FIELDS; i++)
                    if (s_q.dirty[i])
                        s_d.run[i] = s_q.vis[i];
                s_d.dirty = '0;
                s_d.te    = 1'b1;
                s_d.vis   = s_d.run;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.run   <= reset_cal();
            s_q.vis   <= reset_cal();
            s_q.dirty <= '0;
            s_q.te    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (field_sel)
            bus_rdata = s_q.vis[idx];
        else if (ctrl_sel)
            bus_rdata = FIELD_W'(s_q.te) << TE_BIT;
        else
            bus_rdata = '0;
    end
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [FIELD_W-1:0] wdata,
    input logic              te_q,
    input cal_t              run_q,
    input cal_t              vis_q
);
    // R10
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!te_q && !we) |=> $stable(vis_q));

    // R12
    live_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        te_q |-> (vis_q == run_q));

    // R3
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (te_q && tick && !we && run_q[F_SEC] == 8'h59) |=> (run_q[F_SEC] == 8'h00));

    // R3
    hour_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (te_q && tick && !we && run_q[F_HR] == 8'h23 && run_q[F_MIN] == 8'h59
         && run_q[F_SEC] == 8'h59) |=> (run_q[F_HR] == 8'h00));

    // R4
    dow_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && run_q[F_DOW] != 8'h00) |=> (run_q[F_DOW] != 8'h00));

    // R9
    freeze_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == CTRL_ADDR && !wdata[TE_BIT]) |=> !te_q);

    // R11
    release_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!te_q && we && addr == CTRL_ADDR && wdata[TE_BIT]) |=> (te_q && vis_q == run_q));
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_1hz),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .te_q  (s_q.te),
    .run_q (s_q.run),
    .vis_q (s_q.vis)
);

// File: tb/test_rtc_bcd_calendar.sv
module test_rtc_bcd_calendar;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit model_live = 0;

    int m_run [8];
    int m_vis [8];
    bit m_dirty [8];
    bit m_te;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_bcd_calendar i_rtc_bcd_calendar (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata)
    );

    function automatic int bcd2bin(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] bin2bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [7:0] mask_of(input int a);
        case (a)
            0, 1: return 8'h7F;
            2, 4: return 8'h3F;
            3:    return 8'h07;
            5:    return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic int days_in(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_tick();
        m_run[0]++;
        if (m_run[0] == 60) begin
            m_run[0] = 0; m_run[1]++;
            if (m_run[1] == 60) begin
                m_run[1] = 0; m_run[2]++;
                if (m_run[2] == 24) begin
                    m_run[2] = 0;
                    m_run[3] = (m_run[3] == 7) ? 1 : m_run[3] + 1;
                    m_run[4]++;
                    if (m_run[4] > days_in(m_run[5], m_run[6])) begin
                        m_run[4] = 1; m_run[5]++;
                        if (m_run[5] > 12) begin
                            m_run[5] = 1; m_run[6]++;
                            if (m_run[6] == 100) begin
                                m_run[6] = 0;
                                m_run[7] = (m_run[7] + 1) % 100;
                            end
                        end
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = '{0, 0, 0, 1, 1, 1, 0, 20};
            m_vis = m_run;
            foreach (m_dirty[i]) m_dirty[i] = 0;
            m_te = 1;
            model_live = 1;
        end else begin
            if (tick) model_tick();
            if (m_te) begin
                if (we && addr < 8) m_run[addr] = bcd2bin(wdata & mask_of(addr));
                if (we && addr == 4'hF && !wdata[7]) m_te = 0;
                m_vis = m_run;
            end else begin
                if (we && addr < 8) begin
                    m_vis[addr] = bcd2bin(wdata & mask_of(addr));
                    m_dirty[addr] = 1;
                end
                if (we && addr == 4'hF && wdata[7]) begin
                    for (int i = 0; i < 8; i++) if (m_dirty[i]) m_run[i] = m_vis[i];
                    foreach (m_dirty[i]) m_dirty[i] = 0;
                    m_te = 1;
                    m_vis = m_run;
                end
            end
        end
    end

    function automatic logic [7:0] model_read(input logic [3:0] a);
        if (a < 8) return bin2bcd(m_vis[a]);
        if (a == 4'hF) return m_te ? 8'h80 : 8'h00;
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: addr=%h got=%h expected=%h", tag, addr, got, exp);
        end
    endtask

    // every-cycle model comparison
    always @(negedge clk) begin
        if (rst_n && model_live && !done) begin
            if (!m_te && addr < 8)       chk("R10 model", rdata, model_read(addr));
            else if (addr < 3)           chk("R3 model", rdata, model_read(addr));
            else if (addr == 3)          chk("R4 model", rdata, model_read(addr));
            else if (addr == 4)          chk("R5 model", rdata, model_read(addr));
            else if (addr < 8)           chk("R7 model", rdata, model_read(addr));
            else if (addr == 4'hF)       chk("R9 model", rdata, model_read(addr));
            else                         chk("R2 model", rdata, model_read(addr));
        end
    end

    task automatic cyc(input logic t, input logic w, input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        tick = t; we = w; addr = a; wdata = d;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        cyc(1'b0, 1'b0, a, 8'h00);
        @(negedge clk); #1;
        chk(tag, rdata, exp);
    endtask

    task automatic set_time(input logic [7:0] cen, yr, mon, date, dow, hr, mi, se);
        cyc(0, 1, 4'hF, 8'h00);
        cyc(0, 1, 4'h7, cen);
        cyc(0, 1, 4'h6, yr);
        cyc(0, 1, 4'h5, mon);
        cyc(0, 1, 4'h4, date);
        cyc(0, 1, 4'h3, dow);
        cyc(0, 1, 4'h2, hr);
        cyc(0, 1, 4'h1, mi);
        cyc(0, 1, 4'h0, se);
        cyc(0, 1, 4'hF, 8'h80);
        cyc(0, 0, 4'h0, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: run did not finish, got=hung expected=done");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd_chk(4'h0, 8'h00, "R1"); rd_chk(4'h1, 8'h00, "R1");
        rd_chk(4'h2, 8'h00, "R1"); rd_chk(4'h3, 8'h01, "R1");
        rd_chk(4'h4, 8'h01, "R1"); rd_chk(4'h5, 8'h01, "R1");
        rd_chk(4'h6, 8'h00, "R1"); rd_chk(4'h7, 8'h20, "R1");
        rd_chk(4'hF, 8'h80, "R1");

        // R2 unused addresses
        cyc(0, 1, 4'h9, 8'hA5);
        rd_chk(4'h9, 8'h00, "R2");
        rd_chk(4'hE, 8'h00, "R2");

        // R3 R4 R6 leap February
        set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h58);
        cyc(1, 0, 4'h0, 8'h00);
        rd_chk(4'h0, 8'h59, "R3");
        cyc(1, 0, 4'h0, 8'h00);
        rd_chk(4'h0, 8'h00, "R3");
        rd_chk(4'h1, 8'h00, "R3");
        rd_chk(4'h2, 8'h00, "R3");
        rd_chk(4'h4, 8'h29, "R6");
        rd_chk(4'h3, 8'h04, "R4");

        set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h07, 8'h23, 8'h59, 8'h59);
        cyc(1, 0, 4'h0, 8'h00);
        rd_chk(4'h4, 8'h01, "R6");
        rd_chk(4'h5, 8'h03, "R6");
        rd_chk(4'h3, 8'h01, "R4");

        // R6 non-leap year
        set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        cyc(1, 0, 4'h0, 8'h00);
        rd_chk(4'h4, 8'h01, "R6");
        rd_chk(4'h5, 8'h03, "R6");

        // R5 30- and 31-day months
        set_time(8'h20, 8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        cyc(1, 0, 4'h0, 8'h00);
        rd_chk(4'h4, 8'h01, "R5");
        rd_chk(4'h5, 8'h05, "R5");
        set_time(8'h20, 8'h24, 8'h05, 8'h30, 8'h04, 8'h23, 8'h59, 8'h59);
        cyc(1, 0, 4'h0, 8'h00);
        rd_chk(4'h4, 8'h31, "R5");
        rd_chk(4'h5, 8'h05, "R5");

        // R7 year and century carry
        set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        cyc(1, 0, 4'h0, 8'h00);
        rd_chk(4'h5, 8'h01, "R7");
        rd_chk(4'h6, 8'h00, "R7");
        rd_chk(4'h7, 8'h21, "R7");

        // R8 month upper bits
        cyc(0, 1, 4'h5, 8'hE7);
        rd_chk(4'h5, 8'h07, "R8");

        // R12 live write, R9 R10 R11 freeze and release
        set_time(8'h20, 8'h24, 8'h06, 8'h15, 8'h06, 8'h10, 8'h20, 8'h10);
        cyc(0, 1, 4'h0, 8'h30);
        rd_chk(4'h0, 8'h30, "R12");
        cyc(0, 1, 4'hF, 8'h00);
        rd_chk(4'hF, 8'h00, "R9");
        for (int k = 0; k < 5; k++) cyc(1, 0, 4'h0, 8'h00);
        rd_chk(4'h0, 8'h30, "R10");
        cyc(0, 1, 4'h1, 8'h45);
        rd_chk(4'h1, 8'h45, "R10");
        rd_chk(4'h0, 8'h30, "R10");
        cyc(0, 1, 4'hF, 8'h80);
        rd_chk(4'hF, 8'h80, "R9");
        rd_chk(4'h1, 8'h45, "R11");
        rd_chk(4'h0, 8'h35, "R11");
        rd_chk(4'h2, 8'h10, "R11");

        // long run across a century boundary, model-compared each cycle
        set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h00, 8'h00);
        for (int k = 0; k < 4000; k++) cyc(1, 0, 4'(k % 8), 8'h00);
        rd_chk(4'h7, 8'h21, "R7");
        rd_chk(4'h3, 8'h01, "R4");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule